// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block holds the 16-bit status and control word of a single downstream port of a root hub, together with the small state machine behind it. Software writes the whole word in one cycle through a plain write strobe. It reads the current word at any time on a combinational readback bus. The device side of the port is modelled by a few inputs: attach, low-speed, the two line-state levels, overcurrent, and a remote-wakeup request. The block drives three signalling indications outward: port reset, resume drive, and the short low-speed end-of-packet tail that closes a resume.

The three change flags record hardware events: a connect change, a hardware-caused loss of enable, and an overcurrent change. Software acknowledges a flag by writing a one to its bit. Resume signalling has no internal timeout. It stays on until software clears it, and the resume bit then stays set until the end-of-packet tail has been sent. The tail length is derived from the clock frequency parameter: three low-speed bit times of 1/1.5 MHz each.

Bit positions are: 0 connected, 1 connect change, 2 enabled, 3 enable change, 5:4 line state, 6 resume, 7 constant one, 8 low speed, 9 reset, 10 overcurrent, 11 overcurrent change, 12 suspend, 15:13 reserved zero.

Top module: `rport_stat_ctl`

## Requirements
- R1: After reset the readback is 16'h0080 and drv_reset, drv_resume and drv_eop are all low.
- R2: Writing a one to bit 1, bit 3 or bit 11 clears that change flag. Writing a zero to that bit leaves the flag unchanged.
- R3: Bits 15:13 always read zero and bit 7 always reads one, whatever value is written to them.
- R4: A change of the attach input sets bit 1, and a change of the overcurrent input sets bit 11, one clock later. If a hardware set and a one-write clear fall in the same cycle, the set wins.
- R5: Writing bit 9 as one while the port is enabled clears bit 2 and sets bit 3. Writing bit 9 back to zero sets bit 1. drv_reset follows bit 9.
- R6: A write that sets bit 6 while the port is disabled has no effect, and bit 6 reads zero.
- R7: While the port is enabled and bit 12 is set, a wake request sets bit 6 and raises drv_resume.
- R8: Once set, bit 6 stays set without limit until software clears it or the port is disabled.
- R9: A write with bit 6 zero while resume is active starts the end-of-packet tail. drv_eop is high and drv_resume is low for EOP_CYC cycles, which is 12 at the default 6 MHz clock, while bit 6 stays one. Bit 6 then drops together with drv_eop.
- R10: A write with bit 2 zero, a write with bit 9 one, or a detach clears bit 6 and bit 12 at once, with no tail.
- R11: Bit 2 can be set only while bit 0 is one. A detach while enabled clears bit 2 and sets bit 3.
- R12: Bits 8 and 5:4 show the low-speed and line-state inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 16 | Word written |
| rd_data | output | 16 | Current status word |
| dev_attach | input | 1 | Device attached |
| dev_lowspeed | input | 1 | Attached device is low speed |
| line_state | input | 2 | Line level pair |
| ovc_in | input | 1 | Overcurrent indication |
| wake_req | input | 1 | Remote-wakeup request from the device |
| drv_reset | output | 1 | Port reset being driven |
| drv_resume | output | 1 | Resume signalling being driven |
| drv_eop | output | 1 | Low-speed end-of-packet tail being sent |

## Verification
The main collision is a hardware event that sets a change flag in the same cycle as a software write that clears that flag. The bench provokes it by dropping dev_attach on the very edge where it writes a one to bit 1 and keeps bit 2 set in the same write. The correct outcome is that bit 1 is still set, bit 2 has dropped and bit 3 is set. A second overlap is a write that clears the resume bit while the port stays enabled. The bench judges it by counting the cycles drv_eop stays high and checking that bit 6 falls on the same edge as drv_eop.

// File: rtl/rps_pkg.sv
`timescale 1ns/1ps
package rps_pkg;
   localparam int REG_W  = 16;
   localparam int B_CCS  = 0;
   localparam int B_CSC  = 1;
   localparam int B_EN   = 2;
   localparam int B_ENC  = 3;
   localparam int B_LN0  = 4;
   localparam int B_RD   = 6;
   localparam int B_ONE  = 7;
   localparam int B_LOW  = 8;
   localparam int B_RST  = 9;
   localparam int B_OC   = 10;
   localparam int B_OCC  = 11;
   localparam int B_SUSP = 12;
   localparam int N_FLAG = 3;

   // low-speed bit time is 1/1500 kHz; round the tail up to whole clocks
   function automatic int eop_cycles(input int clk_khz, input int bits);
      return (bits * clk_khz + 1499) / 1500;
   endfunction
endpackage

// File: rtl/rps_change_flag.sv
`timescale 1ns/1ps
module rps_change_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag
);
   // a hardware event outranks an acknowledge in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)        flag <= 1'b0;
      else if (set_evt)  flag <= 1'b1;
      else if (clr_req)  flag <= 1'b0;
   end
endmodule

// File: rtl/rps_eop_timer.sv
`timescale 1ns/1ps
module rps_eop_timer #(
   parameter int CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic abort,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYC + 1);
   logic [CW-1:0] cnt;

   generate
      if (CYC < 1) begin : g_bad
         $error("rps_eop_timer: CYC must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || abort)   cnt <= '0;
      else if (start)        cnt <= CW'(CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1)) && !abort;
endmodule

// File: rtl/rport_stat_ctl.sv
`timescale 1ns/1ps
module rport_stat_ctl #(
   parameter int CLK_KHZ  = 6000,
   parameter int EOP_BITS = 3
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   input  logic        dev_attach,
   input  logic        dev_lowspeed,
   input  logic [1:0]  line_state,
   input  logic        ovc_in,
   input  logic        wake_req,
   output logic        drv_reset,
   output logic        drv_resume,
   output logic        drv_eop
);
   import rps_pkg::*;

   localparam int EOP_CYC = eop_cycles(CLK_KHZ, EOP_BITS);

   generate
      if (CLK_KHZ < 1500) begin : g_slow
         $error("rport_stat_ctl: clock must be at least 1.5 MHz");
      end
      if (EOP_BITS < 1) begin : g_nobits
         $error("rport_stat_ctl: EOP_BITS must be positive");
      end
   endgenerate

   logic       ccs_q, ovc_q, low_q, pe_q, pr_q, rd_q, susp_q;
   logic [1:0] line_q;
   logic       ccs_fall, rst_on, rst_off, kill, hw_dis;
   logic       tail_busy, tail_done, tail_start, pe_d;
   logic [N_FLAG-1:0] set_v, clr_v, flag_v;

   // reserved and read-only positions are ignored on write
   logic unused_wr;
   assign unused_wr = ^{wr_data[15:13], wr_data[B_OC], wr_data[B_LOW],
                        wr_data[B_ONE], wr_data[5:4], wr_data[B_CCS]};

   assign ccs_fall = ccs_q & ~dev_attach;
   assign rst_on   = wr_en & wr_data[B_RST];
   assign rst_off  = pr_q & wr_en & ~wr_data[B_RST];
   assign kill     = ccs_fall | (wr_en & (wr_data[B_RST] | ~wr_data[B_EN]));
   assign hw_dis   = pe_q & (rst_on | ccs_fall);

   always_comb begin
      if (rst_on || ccs_fall) pe_d = 1'b0;
      else if (wr_en)         pe_d = wr_data[B_EN] & ccs_q;
      else                    pe_d = pe_q;
   end

   // flag order: 0 connect, 1 enable, 2 overcurrent
   assign set_v[0] = (dev_attach ^ ccs_q) | rst_off;
   assign set_v[1] = hw_dis;
   assign set_v[2] = ovc_in ^ ovc_q;
   assign clr_v[0] = wr_en & wr_data[B_CSC];
   assign clr_v[1] = wr_en & wr_data[B_ENC];
   assign clr_v[2] = wr_en & wr_data[B_OCC];

   generate
      for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
         rps_change_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_v[g]),
            .clr_req (clr_v[g]),
            .flag    (flag_v[g])
         );
      end
   endgenerate

   assign tail_start = rd_q & ~tail_busy & ~kill & wr_en & ~wr_data[B_RD];

   rps_eop_timer #(.CYC(EOP_CYC)) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tail_start),
      .abort (kill),
      .busy  (tail_busy),
      .done  (tail_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ccs_q  <= 1'b0;
         ovc_q  <= 1'b0;
         low_q  <= 1'b0;
         line_q <= 2'b00;
         pe_q   <= 1'b0;
         pr_q   <= 1'b0;
      end else begin
         ccs_q  <= dev_attach;
         ovc_q  <= ovc_in;
         low_q  <= dev_lowspeed;
         line_q <= line_state;
         pe_q   <= pe_d;
         if (wr_en) pr_q <= wr_data[B_RST];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         susp_q <= 1'b0;
      end else if (kill) begin
         rd_q   <= 1'b0;
         susp_q <= 1'b0;
      end else begin
         if (wr_en && pe_q) susp_q <= wr_data[B_SUSP];
         if (tail_done)
            rd_q <= 1'b0;
         else if (!rd_q && pe_q &&
                  ((wr_en && wr_data[B_RD]) || (!wr_en && susp_q && wake_req)))
            rd_q <= 1'b1;
      end
   end

   always_comb begin
      rd_data          = '0;
      rd_data[B_CCS]   = ccs_q;
      rd_data[B_CSC]   = flag_v[0];
      rd_data[B_EN]    = pe_q;
      rd_data[B_ENC]   = flag_v[1];
      rd_data[5:4]     = line_q;
      rd_data[B_RD]    = rd_q;
      rd_data[B_ONE]   = 1'b1;
      rd_data[B_LOW]   = low_q;
      rd_data[B_RST]   = pr_q;
      rd_data[B_OC]    = ovc_q;
      rd_data[B_OCC]   = flag_v[2];
      rd_data[B_SUSP]  = susp_q;
   end

   assign drv_reset  = pr_q;
   assign drv_eop    = tail_busy;
   assign drv_resume = rd_q & ~tail_busy;
endmodule

// File: rtl/rps_chk.sv
`timescale 1ns/1ps
module rps_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [15:0] wr_data,
   input logic        dev_attach,
   input logic [15:0] rd_data,
   input logic        drv_eop,
   input logic        drv_resume
);
   a_r9_eop_excl: assert property (@(posedge clk) disable iff (!rst_n)
      drv_eop |-> !drv_resume);

   a_r9_rd_drops_with_eop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_eop) |-> !rd_data[6]);

   a_r6_rd_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[6] |-> rd_data[2]);

   a_r8_resume_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[6] && !wr_en && !drv_eop && dev_attach) |=> rd_data[6]);

   a_r5_reset_disables: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[9] && rd_data[2]) |=> (rd_data[3] && !rd_data[2]));

   a_r4_connect_change: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_attach != rd_data[0]) |=> rd_data[1]);
endmodule

bind rport_stat_ctl rps_chk u_rps_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_data    (wr_data),
   .dev_attach (dev_attach),
   .rd_data    (rd_data),
   .drv_eop    (drv_eop),
   .drv_resume (drv_resume)
);

// File: tb/test_rport_stat_ctl.sv
`timescale 1ns/1ps
module test_rport_stat_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        dev_attach = 1'b0, dev_lowspeed = 1'b0, ovc_in = 1'b0, wake_req = 1'b0;
   logic [1:0]  line_state = 2'b00;
   logic        drv_reset, drv_resume, drv_eop;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   rport_stat_ctl i_rport_stat_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .dev_attach(dev_attach), .dev_lowspeed(dev_lowspeed), .line_state(line_state),
      .ovc_in(ovc_in), .wake_req(wake_req),
      .drv_reset(drv_reset), .drv_resume(drv_resume), .drv_eop(drv_eop));

   // {attach, ovc, wake, wr_en, wr_data, expected readback}
   localparam int NV = 16;
   localparam logic [35:0] VEC [NV] = '{
      {4'b1000, 16'h0000, 16'h0083},  // R4 attach edge
      {4'b1001, 16'h0002, 16'h0081},  // R2 clear connect change
      {4'b1001, 16'h0004, 16'h0085},  // R11 enable while connected
      {4'b1001, 16'hE004, 16'h0085},  // R3 reserved ones ignored
      {4'b1100, 16'h0000, 16'h0C85},  // R4 overcurrent edge
      {4'b1101, 16'h0804, 16'h0485},  // R2 clear overcurrent change
      {4'b1000, 16'h0000, 16'h0885},  // R4 overcurrent falls
      {4'b1001, 16'h0004, 16'h0885},  // R2 zero leaves flag
      {4'b1001, 16'h0804, 16'h0085},  // R2 one clears
      {4'b1001, 16'h0204, 16'h0289},  // R5 reset while enabled
      {4'b1001, 16'h0000, 16'h008B},  // R5 reset release
      {4'b1001, 16'h000A, 16'h0081},  // R2 clear both
      {4'b1001, 16'h0040, 16'h0081},  // R6 resume while disabled
      {4'b1001, 16'h0004, 16'h0085},  // R11 enable
      {4'b1001, 16'h1004, 16'h1085},  // R7 suspend
      {4'b1010, 16'h0000, 16'h10C5}   // R7 wake request
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [15:0] d);
      @(negedge clk);
      wr_en = we;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1 readback", rd_data, 16'h0080);
      chk("R1 outputs", {13'd0, drv_reset, drv_resume, drv_eop}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         dev_attach = VEC[i][35];
         ovc_in     = VEC[i][34];
         wake_req   = VEC[i][33];
         wr_en      = VEC[i][32];
         wr_data    = VEC[i][31:16];
         @(posedge clk);
         #1;
         wr_en = 1'b0;
         wake_req = 1'b0;
         chk($sformatf("vector %0d (R2-R7,R11)", i), rd_data, VEC[i][15:0]);
      end

      // R8: resume persists with no timeout
      repeat (100) @(posedge clk);
      #1;
      chk("R8 resume held", {rd_data[6], drv_resume}, 16'h0003);

      // R9: clear resume, tail of 12 cycles
      step(1'b1, 16'h0004);
      chk("R9 tail start", rd_data, 16'h00C5);
      chk("R9 eop on", {drv_eop, drv_resume}, 16'h0002);
      repeat (11) @(posedge clk);
      #1;
      chk("R9 tail last cycle", {rd_data[6], drv_eop}, 16'h0003);
      @(posedge clk);
      #1;
      chk("R9 tail end", rd_data, 16'h0085);
      chk("R9 eop off", {drv_eop, drv_resume}, 16'h0000);

      // R10: disable ends resume at once
      step(1'b1, 16'h0044);
      chk("R10 resume set", {rd_data, 15'd0, drv_resume}, {16'h00C5, 16'h0001});
      step(1'b1, 16'h0000);
      chk("R10 disable kills resume", rd_data, 16'h0081);
      chk("R10 resume drive off", {drv_resume, drv_eop}, 16'h0000);

      // R4/R11: detach collides with clear of connect change
      step(1'b1, 16'h0004);
      @(negedge clk);
      dev_attach = 1'b0;
      wr_en = 1'b1;
      wr_data = 16'h0006;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      chk("R4 set beats clear, R11 detach disables", rd_data, 16'h008A);

      // R5: reset drive, R12 mirrors
      @(negedge clk);
      dev_attach = 1'b1;
      dev_lowspeed = 1'b1;
      line_state = 2'b10;
      @(posedge clk);
      #1;
      chk("R12 low speed and line", rd_data, 16'h01AB);
      step(1'b1, 16'h0200);
      chk("R5 reset drive on", {15'd0, drv_reset}, 16'h0001);
      step(1'b1, 16'h0000);
      chk("R5 reset drive off", {15'd0, drv_reset}, 16'h0000);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule